// File: doc/BRIEF.md
# Legacy VGA cycle claim decoder

This block keeps the graphics control word of an integrated graphics function and decides, command by command, whether that function claims a legacy VGA cycle. The control word holds a five-bit pre-allocated memory size code, a VGA disable flag and a sticky lock flag. Once the lock flag is written to one, software can no longer change the word until the next reset.

Each incoming command has a 32-bit address, a two-bit kind (memory read, memory write, I/O read or I/O write) and the memory-space and I/O-space enables of the function. The claim output is combinational and is valid in the same cycle as the command strobe. A memory command is claimed only inside the legacy frame buffer window. An I/O command is claimed only inside the two legacy VGA register windows, using the low 16 address bits. Claiming needs a non-zero size code and an effective VGA disable of zero. The effective disable is the stored flag ORed with a device-disabled input. The block also reports the class sub-code byte, which shows whether the function presents itself as a VGA controller, and the memory size in megabytes that the stored code selects.

Top module: `vga_claim_top`

## Requirements
- R1: After reset the control word reads 00000028h: size code 5 in bits 7:3, disable bit 1 clear and lock bit 0 clear.
- R2: While the word is unlocked, a write loads bits 7:3 (size code), bit 1 (VGA disable) and bit 0 (lock) from the write data. Bit 2 and bits 31:8 always read zero, whatever was written.
- R3: Once the lock bit reads 1, every later write leaves the whole word unchanged until reset. After a reset the word is writable again.
- R4: Command kind is encoded 00 memory read, 01 memory write, 10 I/O read, 11 I/O write. A memory command is claimed only when the memory-space enable is 1 and the full 32-bit address lies in 000A0000h..000BFFFFh inclusive.
- R5: An I/O command is claimed only when the I/O-space enable is 1 and address bits 15:0 lie in 03B0h..03BBh or 03C0h..03DFh inclusive. Address bits 31:16 are ignored.
- R6: With a size code of zero, no memory or I/O command is claimed.
- R7: With the stored disable bit at 1, or the device-disabled input at 1, no command is claimed.
- R8: The sub-class output is 00h when the size code is non-zero and the effective disable is 0. Otherwise it is 80h.
- R9: The size output in MB equals code x 32 for codes 0 to 16 (16 gives 512). Reserved codes 17 to 31 report 0.
- R10: The claim output is valid combinationally in the cycle where the command strobe is high. It is 0 whenever the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Current control word |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 2 | Command kind (R4 encoding) |
| cmd_addr | input | 32 | Command address |
| mem_space_en | input | 1 | Memory-space decode enable |
| io_space_en | input | 1 | I/O-space decode enable |
| dev_disabled | input | 1 | Forces the effective VGA disable |
| claim | output | 1 | Function claims the current command |
| sub_class | output | 8 | Class sub-code byte |
| alloc_mb | output | 10 | Pre-allocated memory size in MB |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a five-bit size code at bit 3, one memory window and two I/O windows at the legacy addresses. These defaults put every window edge within reach of a single directed command: 9FFFFh, A0000h, BFFFFh, C0000h, 03AFh, 03BBh, 03BCh, 03BFh, 03C0h, 03DFh and 03E0h. Upper address bits are also set, to show the 32-bit memory compare against the 16-bit I/O compare. Every size code, including the reserved ones, is also stepped through. The lock sequence is followed by a reset so that both the sticky hold and its release are observed.

// File: rtl/vga_claim_pkg.sv
package vga_claim_pkg;

  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'b00,
    CMD_MEM_WR = 2'b01,
    CMD_IO_RD  = 2'b10,
    CMD_IO_WR  = 2'b11
  } cmd_kind_e;

  localparam int unsigned CODE_W    = 5;
  localparam int unsigned MB_W      = 10;
  localparam int unsigned CODE_MAX  = 16;
  localparam logic [7:0]  SUB_VGA   = 8'h00;
  localparam logic [7:0]  SUB_OTHER = 8'h80;

  // Memory kinds share the upper kind bit cleared.
  function automatic logic kind_is_mem(input logic [1:0] kind);
    return (cmd_kind_e'(kind) == CMD_MEM_RD) || (cmd_kind_e'(kind) == CMD_MEM_WR);
  endfunction

  // Size in MB: 32 MB per code step, reserved codes report zero.
  function automatic logic [MB_W-1:0] alloc_mb_of(input logic [CODE_W-1:0] code);
    if (int'(code) > int'(CODE_MAX)) return '0;
    return {code, 5'b00000};
  endfunction

endpackage

// File: rtl/vga_win_decode.sv
module vga_win_decode #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NWIN = 2,
  parameter logic [NWIN*AW-1:0] LO_LIST = '0,
  parameter logic [NWIN*AW-1:0] HI_LIST = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [NWIN-1:0] hit_vec;

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign hit_vec[i] = in_window(addr, LO_LIST[i*AW +: AW], HI_LIST[i*AW +: AW]);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/vga_ctl_reg.sv
module vga_ctl_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CODE_LSB = 3,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned VD_BIT   = 1,
  parameter int unsigned LOCK_BIT = 0,
  parameter logic [CODE_W-1:0] CODE_RST = 5'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] word_q,
  output logic [CODE_W-1:0] code_q,
  output logic              vd_q,
  output logic              lock_q
);

  localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] CODE_MSK = ((ONE << CODE_W) - ONE) << CODE_LSB;
  localparam logic [DATA_W-1:0] WR_MASK  = CODE_MSK | (ONE << VD_BIT) | (ONE << LOCK_BIT);
  localparam logic [DATA_W-1:0] RST_WORD = DATA_W'(CODE_RST) << CODE_LSB;

  logic write_ok;

  assign write_ok = wr_en && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        word_q <= RST_WORD;
    else if (write_ok) word_q <= wr_data & WR_MASK;
  end

  assign code_q = word_q[CODE_LSB +: CODE_W];
  assign vd_q   = word_q[VD_BIT];
  assign lock_q = word_q[LOCK_BIT];

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(word_q)); // R3

endmodule

// File: rtl/vga_claim_top.sv
module vga_claim_top
  import vga_claim_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IO_W   = 16,
  parameter logic [DATA_W-1:0] MEM_LO = 32'h000A_0000,
  parameter logic [DATA_W-1:0] MEM_HI = 32'h000B_FFFF,
  parameter logic [IO_W-1:0]   IOA_LO = 16'h03B0,
  parameter logic [IO_W-1:0]   IOA_HI = 16'h03BB,
  parameter logic [IO_W-1:0]   IOB_LO = 16'h03C0,
  parameter logic [IO_W-1:0]   IOB_HI = 16'h03DF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic              mem_space_en,
  input  logic              io_space_en,
  input  logic              dev_disabled,
  output logic              claim,
  output logic [7:0]        sub_class,
  output logic [MB_W-1:0]   alloc_mb
);

  logic [CODE_W-1:0] code_q;
  logic              vd_q;
  logic              lock_q;
  logic              eff_vd;
  logic              vga_on;
  logic              is_mem;
  logic              mem_hit;
  logic              io_hit;
  logic              mem_claim_w;
  logic              io_claim_w;

  vga_ctl_reg #(
    .DATA_W  (DATA_W),
    .CODE_LSB(3),
    .CODE_W  (CODE_W),
    .VD_BIT  (1),
    .LOCK_BIT(0),
    .CODE_RST(5'd5)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .word_q (rd_data),
    .code_q (code_q),
    .vd_q   (vd_q),
    .lock_q (lock_q)
  );

  vga_win_decode #(
    .AW     (DATA_W),
    .NWIN   (1),
    .LO_LIST(MEM_LO),
    .HI_LIST(MEM_HI)
  ) u_mem_win (
    .addr(cmd_addr),
    .hit (mem_hit)
  );

  vga_win_decode #(
    .AW     (IO_W),
    .NWIN   (2),
    .LO_LIST({IOB_LO, IOA_LO}),
    .HI_LIST({IOB_HI, IOA_HI})
  ) u_io_win (
    .addr(cmd_addr[IO_W-1:0]),
    .hit (io_hit)
  );

  assign eff_vd      = vd_q | dev_disabled;
  assign vga_on      = (code_q != '0) && !eff_vd;
  assign is_mem      = kind_is_mem(cmd_kind);
  assign mem_claim_w = is_mem  && mem_space_en && mem_hit;
  assign io_claim_w  = !is_mem && io_space_en  && io_hit;
  assign claim       = cmd_valid && vga_on && (mem_claim_w || io_claim_w);
  assign sub_class   = vga_on ? SUB_VGA : SUB_OTHER;
  assign alloc_mb    = alloc_mb_of(code_q);

  AST_CLAIM_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> cmd_valid); // R10
  AST_MEM_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && is_mem) |-> mem_space_en); // R4
  AST_IO_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !is_mem) |-> io_space_en); // R5
  AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0) |-> (!claim && sub_class == SUB_OTHER)); // R6
  AST_DISABLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_disabled || vd_q) |-> !claim); // R7
  AST_CLAIM_VGA_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> (sub_class == SUB_VGA)); // R8
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |=> (rd_data[2] == 1'b0)); // R2

endmodule

// File: tb/tb_vga_claim_top.sv
module tb_vga_claim_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'b00;
  logic [31:0] cmd_addr = '0;
  logic        mem_space_en = 1'b0;
  logic        io_space_en = 1'b0;
  logic        dev_disabled = 1'b0;
  logic        claim;
  logic [7:0]  sub_class;
  logic [9:0]  alloc_mb;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int m_code, m_vd, m_lock;

  always #10 clk = ~clk;

  vga_claim_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .mem_space_en(mem_space_en), .io_space_en(io_space_en), .dev_disabled(dev_disabled),
    .claim(claim), .sub_class(sub_class), .alloc_mb(alloc_mb)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_claim();
    int lo16;
    if (!cmd_valid) return 0;
    if (m_code == 0 || m_vd != 0 || dev_disabled) return 0;
    if (cmd_kind < 2) begin
      if (!mem_space_en) return 0;
      return (cmd_addr >= 32'hA0000 && cmd_addr <= 32'hBFFFF) ? 1 : 0;
    end
    if (!io_space_en) return 0;
    lo16 = int'(cmd_addr % 65536);
    if (lo16 >= 'h3B0 && lo16 <= 'h3BB) return 1;
    if (lo16 >= 'h3C0 && lo16 <= 'h3DF) return 1;
    return 0;
  endfunction

  function automatic int exp_sub();
    return (m_code != 0 && m_vd == 0 && !dev_disabled) ? 'h00 : 'h80;
  endfunction

  function automatic int exp_mb();
    return (m_code > 16) ? 0 : 32 * m_code;
  endfunction

  // Compare all outputs in the current cycle, then advance one clock.
  task automatic cycle(string tag);
    #2;
    check(tag, "claim", claim, exp_claim());
    check(tag, "sub_class", sub_class, exp_sub());
    check(tag, "rd_data", rd_data, m_code * 8 + m_vd * 2 + m_lock);
    check(tag, "alloc_mb", alloc_mb, exp_mb());
    @(posedge clk);
    if (!rst_n) begin
      m_code = 5; m_vd = 0; m_lock = 0;
    end else if (wr_en && m_lock == 0) begin
      m_code = int'(wr_data[7:3]);
      m_vd   = int'(wr_data[1]);
      m_lock = int'(wr_data[0]);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cycle("R1 in reset");
    cycle("R1 in reset");
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [31:0] d, string tag);
    wr_en = 1'b1; wr_data = d;
    cycle(tag);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cmd(logic [1:0] k, logic [31:0] a, string tag);
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a;
    cycle(tag);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] mem_pts [5];
    logic [31:0] io_pts [12];
    mem_pts = '{32'h0009_FFFF, 32'h000A_0000, 32'h000B_FFFF, 32'h000C_0000, 32'h100A_0000};
    io_pts  = '{32'h03AF, 32'h03B0, 32'h03BB, 32'h03BC, 32'h03BF, 32'h03C0,
                32'h03DF, 32'h03E0, 32'h5A5A_03C4, 32'hFFFF_03B5, 32'h0, 32'h000A_0000};
    m_code = 5; m_vd = 0; m_lock = 0;
    @(negedge clk);
    do_reset();
    // R1 reset word, R8 sub-class, R9 size with default code
    cycle("R1 reset word");
    check("R1", "rd_data direct", rd_data, 32'h28);

    // R4 memory window edges, both memory kinds
    mem_space_en = 1'b1; io_space_en = 1'b1;
    foreach (mem_pts[i]) begin
      cmd(2'b00, mem_pts[i], "R4 mem read edge");
      cmd(2'b01, mem_pts[i], "R4 mem write edge");
    end
    mem_space_en = 1'b0;
    cmd(2'b00, 32'h000A_0000, "R4 mem space off");
    mem_space_en = 1'b1;

    // R5 I/O window edges, both I/O kinds
    foreach (io_pts[i]) begin
      cmd(2'b10, io_pts[i], "R5 io read edge");
      cmd(2'b11, io_pts[i], "R5 io write edge");
    end
    cmd(2'b00, 32'h03C0, "R4 mem kind at io addr");
    io_space_en = 1'b0;
    cmd(2'b11, 32'h03D4, "R5 io space off");
    io_space_en = 1'b1;

    // R10 no strobe, address inside window
    cmd_kind = 2'b00; cmd_addr = 32'h000A_8000; cmd_valid = 1'b0;
    cycle("R10 strobe low");
    cmd(2'b00, 32'h000A_8000, "R10 strobe high");

    // R7 device-disabled override
    dev_disabled = 1'b1;
    cmd(2'b00, 32'h000B_0000, "R7 dev disabled mem");
    cmd(2'b10, 32'h03C0, "R7 dev disabled io");
    dev_disabled = 1'b0;

    // R7 stored disable bit
    wr(32'h0000_002A, "R7 set vd");
    cmd(2'b01, 32'h000A_0000, "R7 vd mem");
    cmd(2'b11, 32'h03DF, "R7 vd io");

    // R6 size code zero
    wr(32'h0000_0000, "R6 code zero");
    cmd(2'b00, 32'h000A_0000, "R6 mem");
    cmd(2'b10, 32'h03B0, "R6 io");

    // R2 and R9 every code, with junk in ignored bits
    for (int c = 0; c < 32; c++) begin
      wr(32'hFFFF_FF04 | (32'(c) << 3), "R2 R9 code sweep");
      cycle("R9 size readback");
    end

    // R3 lock: set code 3, lock, then try to change
    wr(32'h0000_0019, "R3 lock write");
    wr(32'h0000_0042, "R3 locked write");
    wr(32'h0000_0000, "R3 locked write zero");
    check("R3", "held word", rd_data, 32'h19);
    cmd(2'b10, 32'h03BA, "R3 locked still claims");
    do_reset();
    cycle("R3 after reset");
    wr(32'h0000_0080, "R3 writable again");
    cycle("R9 code 16");
    check("R9", "512 MB", alloc_mb, 512);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule